// File: doc/BRIEF.md
# ADC Sample Packer with Per-Channel Averaging

This block sits between a multi-channel ADC sequencer and a byte-wide memory write port. A start pulse latches a channel-enable mask, a sample-count exponent and a base address. The block then walks the enabled channels from the lowest index upward. For each channel it takes a fixed number of conversion results over a valid/ready input. It writes every result to memory as two bytes and adds it to a running sum. After the channel's last sample it appends a four-byte trailer: the channel index, the remainder of the sum divided by the sample count, and the average.

The sample count n is a power of two, from 1 to 256. The average is therefore a right shift of the sum, and the remainder is the bits that the shift drops. The block tells the sequencer which channel it wants through a current-channel output. While a byte is waiting to be written, the block holds its sample input off. When the last trailer byte has been accepted, the block pulses done for one cycle and returns to idle.

Top module: `adcpk_top`

## Requirements
- R1: Each accepted sample is written as two bytes at consecutive addresses. Bits 15:8 go to the lower address and bits 7:0 to the next one.
- R2: Only channels whose bit is set in `ch_en` are stored, in ascending channel index. The first block starts at `base_addr`. Each block is 2n+4 bytes long and follows the previous one with no gap, so the m-th enabled channel starts at base + (m-1)(2n+4). Addresses wrap modulo 2^16.
- R3: The byte after a channel's n samples holds that channel's index, zero-extended.
- R4: The next byte holds the sum of the channel's n samples modulo n.
- R5: The last two bytes of a block hold floor(sum / n), bits 15:8 first and then bits 7:0.
- R6: n = 2^`cnt_log2`, and any `cnt_log2` value above 8 acts as 8. The running sum starts from zero for every channel. It does not overflow for 256 samples of 16'hFFFF.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R8: `smp_ready` is never high in a cycle in which `wr_valid` is high, and this includes all trailer bytes.
- R9: `done` is high for exactly one cycle: the cycle after the final trailer byte is accepted. After that the block is idle and writes nothing.
- R10: A start with an all-zero `ch_en` raises `done` in the cycle after the start pulse and performs no writes.
- R11: A start pulse while the block is busy has no effect on the byte stream.
- R12: While `smp_ready` is high, `cur_chan` gives the index of the channel whose samples are being taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| ch_en | input | 8 | Channel-enable mask, bit i for channel i |
| cnt_log2 | input | 4 | log2 of samples per channel (values above 8 act as 8) |
| base_addr | input | 16 | First byte address of the run |
| smp_valid | input | 1 | Sample input valid |
| smp_data | input | 16 | Conversion result |
| smp_ready | output | 1 | Block accepts a sample |
| cur_chan | output | 3 | Channel whose samples are requested |
| wr_valid | output | 1 | Byte write request |
| wr_ready | input | 1 | Memory accepts the byte |
| wr_addr | output | 16 | Byte address |
| wr_data | output | 8 | Byte value |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The main function is exercised with several mask shapes, each telling apart a different kind of error. A single low channel, a single high channel and the two extreme bits separate ordering errors from offset errors. A full mask checks that the blocks chain with no gap. A sparse mask whose base sits near the top of the address space shows that addresses wrap and that disabled channels are skipped.

The sample counts range over n=1, small powers of two and 256. One run with n=256 uses all-ones samples, which shows that the sum neither overflows nor carries over from the previous channel. An out-of-range exponent checks the clamp.

Write back-pressure and input gaps come in three patterns, so that a wrong hold or a wrong stall shows up as a byte mismatch. A start pulse in the middle of a run, an all-zero mask and the reset state are covered by directed tests.

// File: rtl/adcpk_pkg.sv
package adcpk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_WAIT,
    ST_HI,
    ST_LO,
    ST_CHN,
    ST_REM,
    ST_AVH,
    ST_AVL
  } pk_state_e;

  // Effective exponent: anything above the supported maximum acts as the maximum.
  function automatic int unsigned clamp_l2(input int unsigned raw, input int unsigned maxl);
    return (raw > maxl) ? maxl : raw;
  endfunction

  function automatic logic is_trailer(input pk_state_e s);
    return (s == ST_CHN) || (s == ST_REM) || (s == ST_AVH) || (s == ST_AVL);
  endfunction

  function automatic logic is_write(input pk_state_e s);
    return (s == ST_HI) || (s == ST_LO) || is_trailer(s);
  endfunction

endpackage

// File: rtl/adcpk_chan_pick.sv
module adcpk_chan_pick #(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] pend,
  output logic           any,
  output logic [NCH-1:0] oh,
  output logic [CW-1:0]  idx
);

  logic [NCH:0] seen;
  assign seen[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_chain
      assign oh[gi]     = pend[gi] & ~seen[gi];
      assign seen[gi+1] = seen[gi] | pend[gi];
    end
  endgenerate

  assign any = seen[NCH];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (oh[i]) idx = CW'(i);
    end
  end

  // R2: at most one channel is picked, and one is picked whenever any is pending
  always_comb begin
    a_r2_one_pick : assert ($onehot0(oh) && ((|oh) == (|pend)))
      else $error("a_r2_one_pick: pick vector %b for pending %b", oh, pend);
  end

endmodule

// File: rtl/adcpk_accum.sv
module adcpk_accum #(
  parameter int SW   = 16,
  parameter int MAXL = 8,
  localparam int AW  = SW + MAXL,
  localparam int LW  = $clog2(MAXL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic [SW-1:0] din,
  input  logic [LW-1:0] log2n,
  output logic [SW-1:0] avg,
  output logic [MAXL-1:0] rem
);

  logic [AW-1:0] acc;

  function automatic logic [SW-1:0] avg_of(input logic [AW-1:0] s, input logic [LW-1:0] l);
    return SW'(s >> l);
  endfunction

  function automatic logic [MAXL-1:0] rem_of(input logic [AW-1:0] s, input logic [LW-1:0] l);
    logic [AW-1:0] m;
    m = (AW'(1) << l) - AW'(1);
    return MAXL'(s & m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (add) acc <= acc + AW'(din);
  end

  assign avg = avg_of(acc, log2n);
  assign rem = rem_of(acc, log2n);

  // R6: the running sum never wraps while samples are added
  a_r6_no_wrap : assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clr) |=> (acc >= $past(acc)))
    else $error("a_r6_no_wrap: sum wrapped");

  // R6: a clear leaves the sum at zero
  a_r6_clear : assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (avg == '0 && rem == '0))
    else $error("a_r6_clear: sum not cleared");

endmodule

// File: rtl/adcpk_byte_sel.sv
module adcpk_byte_sel
  import adcpk_pkg::*;
#(
  parameter int SW   = 16,
  parameter int CW   = 3,
  parameter int MAXL = 8
) (
  input  pk_state_e       st,
  input  logic [SW-1:0]   samp,
  input  logic [CW-1:0]   chan,
  input  logic [MAXL-1:0] rem,
  input  logic [SW-1:0]   avg,
  output logic [7:0]      data
);

  always_comb begin
    unique case (st)
      ST_HI:   data = 8'(samp >> 8);
      ST_LO:   data = samp[7:0];
      ST_CHN:  data = 8'(chan);
      ST_REM:  data = 8'(rem);
      ST_AVH:  data = 8'(avg >> 8);
      ST_AVL:  data = avg[7:0];
      default: data = 8'h00;
    endcase
  end

endmodule

// File: rtl/adcpk_top.sv
module adcpk_top
  import adcpk_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int SW     = 16,
  parameter int ADDR_W = 16,
  parameter int MAXL   = 8,
  localparam int CW    = $clog2(NCH),
  localparam int LW    = $clog2(MAXL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NCH-1:0]    ch_en,
  input  logic [LW-1:0]     cnt_log2,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              smp_valid,
  input  logic [SW-1:0]     smp_data,
  output logic              smp_ready,
  output logic [CW-1:0]     cur_chan,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done
);

  pk_state_e         st;
  logic [NCH-1:0]    pend;
  logic [LW-1:0]     l2;
  logic [ADDR_W-1:0] addr;
  logic [SW-1:0]     samp;
  logic [CW-1:0]     cur;
  logic [MAXL-1:0]   cnt;

  logic              pick_any;
  logic [NCH-1:0]    pick_oh;
  logic [CW-1:0]     pick_idx;
  logic [SW-1:0]     avg;
  logic [MAXL-1:0]   rem;

  // Named internal events
  logic smp_fire, wr_fire, run_begin, chan_open, last_smp, trailer_end;
  logic [MAXL-1:0] cnt_top;

  assign smp_ready   = (st == ST_WAIT);
  assign wr_valid    = is_write(st);
  assign smp_fire    = smp_valid && smp_ready;
  assign wr_fire     = wr_valid && wr_ready;
  assign run_begin   = start && (st == ST_IDLE);
  assign chan_open   = (st == ST_SEL) && pick_any;
  assign done        = (st == ST_SEL) && !pick_any;
  assign cnt_top     = MAXL'(((MAXL+1)'(1) << l2) - (MAXL+1)'(1));
  assign last_smp    = (cnt == cnt_top);
  assign trailer_end = (st == ST_AVL) && wr_fire;
  assign wr_addr     = addr;
  assign cur_chan    = cur;

  adcpk_chan_pick #(.NCH(NCH)) u_pick (
    .pend (pend),
    .any  (pick_any),
    .oh   (pick_oh),
    .idx  (pick_idx)
  );

  adcpk_accum #(.SW(SW), .MAXL(MAXL)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (chan_open),
    .add   (smp_fire),
    .din   (smp_data),
    .log2n (l2),
    .avg   (avg),
    .rem   (rem)
  );

  adcpk_byte_sel #(.SW(SW), .CW(CW), .MAXL(MAXL)) u_bsel (
    .st   (st),
    .samp (samp),
    .chan (cur),
    .rem  (rem),
    .avg  (avg),
    .data (wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      pend <= '0;
      l2   <= '0;
      addr <= '0;
      samp <= '0;
      cur  <= '0;
      cnt  <= '0;
    end else begin
      if (wr_fire) addr <= addr + ADDR_W'(1);
      unique case (st)
        ST_IDLE: if (run_begin) begin
          pend <= ch_en;
          l2   <= LW'(clamp_l2(int'(cnt_log2), MAXL));
          addr <= base_addr;
          st   <= ST_SEL;
        end
        ST_SEL: if (pick_any) begin
          cur  <= pick_idx;
          pend <= pend & ~pick_oh;
          cnt  <= '0;
          st   <= ST_WAIT;
        end else begin
          st   <= ST_IDLE;
        end
        ST_WAIT: if (smp_fire) begin
          samp <= smp_data;
          st   <= ST_HI;
        end
        ST_HI: if (wr_fire) st <= ST_LO;
        ST_LO: if (wr_fire) begin
          if (last_smp) st <= ST_CHN;
          else begin
            cnt <= cnt + MAXL'(1);
            st  <= ST_WAIT;
          end
        end
        ST_CHN: if (wr_fire) st <= ST_REM;
        ST_REM: if (wr_fire) st <= ST_AVH;
        ST_AVH: if (wr_fire) st <= ST_AVL;
        ST_AVL: if (trailer_end) st <= ST_SEL;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: a stalled byte is held unchanged
  a_r7_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)))
    else $error("a_r7_hold: stalled byte changed");

  // R2: every accepted byte advances the address by one
  a_r2_addr_step : assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (wr_addr == $past(wr_addr) + ADDR_W'(1)))
    else $error("a_r2_addr_step: address did not step");

  // R8: no sample is taken while a byte is waiting
  a_r8_stall_input : assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !smp_ready)
    else $error("a_r8_stall_input: sample input open during write");

  // R9: done lasts one cycle
  a_r9_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("a_r9_done_pulse: done held");

  // R9: done follows the final trailer byte
  a_r9_done_after_trailer : assert property (@(posedge clk) disable iff (!rst_n)
    (trailer_end && pend == '0) |=> done)
    else $error("a_r9_done_after_trailer: missing done");

  // R10: empty mask finishes at once
  a_r10_empty_mask : assert property (@(posedge clk) disable iff (!rst_n)
    (run_begin && ch_en == '0) |=> (done && !wr_valid))
    else $error("a_r10_empty_mask: empty run misbehaved");

  // R4: remainder byte is below n
  a_r4_rem_range : assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REM) |-> ({1'b0, wr_data} < (9'(1) << l2)))
    else $error("a_r4_rem_range: remainder out of range");

  // R11: a start while busy leaves the current channel untouched
  a_r11_busy_start : assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != ST_IDLE && st != ST_SEL) |=> $stable(cur_chan))
    else $error("a_r11_busy_start: channel changed by start");

endmodule

// File: tb/tb_adcpk_top.sv
module tb_adcpk_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  ch_en = '0;
  logic [3:0]  cnt_log2 = '0;
  logic [15:0] base_addr = '0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        smp_ready;
  logic [2:0]  cur_chan;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        done;

  int n_chk = 0;
  int n_err = 0;
  int cyc_total = 0;

  always #10 clk = ~clk;

  adcpk_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ch_en(ch_en), .cnt_log2(cnt_log2),
    .base_addr(base_addr), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .cur_chan(cur_chan), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  // {busy_start, bp, seed, base, log2, mask}
  localparam int NV = 7;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h11, 16'h0100, 4'd0,  8'h01},
    {1'b0, 2'd1, 8'h5A, 16'h2000, 4'd2,  8'h81},
    {1'b1, 2'd2, 8'h33, 16'h3000, 4'd1,  8'hFF},
    {1'b0, 2'd1, 8'h7E, 16'hFFF0, 4'd3,  8'h2C},
    {1'b0, 2'd0, 8'h00, 16'h0000, 4'd8,  8'h10},
    {1'b0, 2'd1, 8'h44, 16'h0800, 4'd12, 8'h06},
    {1'b0, 2'd2, 8'h9D, 16'h1234, 4'd4,  8'h80}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] smp_of(input int seed, input int ch, input int k);
    if (seed == 0) return 16'hFFFF;
    return 16'((seed * 1021 + ch * 4099 + k * (257 + seed)) ^ (k << 3));
  endfunction

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_vec(input logic [7:0] mask, input logic [3:0] l2raw,
                         input logic [15:0] base, input int seed, input int bp,
                         input bit busy);
    logic [15:0] e_addr[$];
    logic [7:0]  e_data[$];
    int          e_tag[$];
    int          ch_order[$];
    logic [15:0] g_addr[$];
    logic [7:0]  g_data[$];
    int  n, l2e, ci, took, ndone, last_wr, done_cyc, cyc;
    int  k[8];
    longint sum;
    logic [15:0] a, s, avg;
    bit  held;
    logic [15:0] h_addr;
    logic [7:0]  h_data;
    int  r8_bad, r12_bad, r7_bad;

    l2e = (l2raw > 8) ? 8 : int'(l2raw);
    n = 1;
    for (int i = 0; i < l2e; i++) n = n * 2;
    a = base;
    for (int ch = 0; ch < 8; ch++) begin
      if (mask[ch]) begin
        ch_order.push_back(ch);
        sum = 0;
        for (int j = 0; j < n; j++) begin
          s = smp_of(seed, ch, j);
          sum += s;
          e_addr.push_back(a); e_data.push_back(s[15:8]); e_tag.push_back(1); a++;
          e_addr.push_back(a); e_data.push_back(s[7:0]);  e_tag.push_back(1); a++;
        end
        avg = 16'(sum / n);
        e_addr.push_back(a); e_data.push_back(8'(ch));        e_tag.push_back(3); a++;
        e_addr.push_back(a); e_data.push_back(8'(sum % n));   e_tag.push_back(4); a++;
        e_addr.push_back(a); e_data.push_back(avg[15:8]);     e_tag.push_back(5); a++;
        e_addr.push_back(a); e_data.push_back(avg[7:0]);      e_tag.push_back(5); a++;
      end
    end

    for (int i = 0; i < 8; i++) k[i] = 0;
    ci = 0; took = 0; ndone = 0; last_wr = -1; done_cyc = -1;
    held = 0; r8_bad = 0; r12_bad = 0; r7_bad = 0;

    @(negedge clk);
    start = 1'b1; ch_en = mask; cnt_log2 = l2raw; base_addr = base;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (ndone == 0 && cyc < 40000) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      start    = busy && (cyc == 20);
      if (busy && cyc == 20) ch_en = 8'h01;
      wr_ready  = (bp == 0) ? 1'b1 : (bp == 1) ? cyc[0] : ((cyc % 3) != 0);
      smp_valid = (bp == 2) ? ((cyc % 4) != 1) : 1'b1;
      smp_data  = smp_of(seed, int'(cur_chan), k[cur_chan]);
      #1;
      if (held) begin
        if (!(wr_valid && wr_addr == h_addr && wr_data == h_data)) r7_bad++;
        held = 0;
      end
      if (wr_valid && !wr_ready) begin
        held = 1; h_addr = wr_addr; h_data = wr_data;
      end
      if (wr_valid && smp_ready) r8_bad++;
      if (wr_valid && wr_ready) begin
        g_addr.push_back(wr_addr); g_data.push_back(wr_data); last_wr = cyc;
      end
      if (smp_valid && smp_ready) begin
        if (ci >= ch_order.size() || int'(cur_chan) != ch_order[ci]) r12_bad++;
        k[cur_chan]++;
        took++;
        if (took == n) begin ci++; took = 0; end
      end
      if (done) begin ndone++; done_cyc = cyc; end
    end
    start = 1'b0;
    ch_en = mask;

    chk(ndone == 1, "R9", "done seen (watchdog)", ndone, 1);
    chk(g_addr.size() == e_addr.size(), "R2", "byte count", g_addr.size(), e_addr.size());
    for (int i = 0; i < e_addr.size() && i < g_addr.size(); i++) begin
      chk(g_addr[i] == e_addr[i], "R2", $sformatf("addr of byte %0d", i), g_addr[i], e_addr[i]);
      chk(g_data[i] == e_data[i], tag_name(e_tag[i]), $sformatf("data of byte %0d", i),
          g_data[i], e_data[i]);
    end
    chk(done_cyc == last_wr + 1, "R9", "done cycle after last byte", done_cyc, last_wr + 1);
    chk(r7_bad == 0, "R7", "stalled byte changed count", r7_bad, 0);
    chk(r8_bad == 0, "R8", "input open during write count", r8_bad, 0);
    chk(r12_bad == 0, "R12", "cur_chan mismatches", r12_bad, 0);
    chk(ci == ch_order.size(), "R6", "channels completed", ci, ch_order.size());

    // R9: one cycle later, done is low and no write is pending
    @(negedge clk);
    #1;
    chk(!done, "R9", "done after pulse", done, 0);
    chk(!wr_valid, "R9", "write after done", wr_valid, 0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc_total++;
      if (cyc_total > 190000) begin
        n_err++;
        $display("FAIL watchdog: actual %0d cycles expected under 190000", cyc_total);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!wr_valid, "R9", "reset wr_valid", wr_valid, 0);
    chk(!smp_ready, "R8", "reset smp_ready", smp_ready, 0);
    chk(!done, "R10", "reset done", done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_vec(VEC[v][7:0], VEC[v][11:8], VEC[v][27:12], int'(VEC[v][35:28]),
              int'(VEC[v][37:36]), VEC[v][38]);
    end

    // R10: empty mask
    @(negedge clk);
    start = 1'b1; ch_en = 8'h00; cnt_log2 = 4'd3; base_addr = 16'h4000;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(done, "R10", "done after empty start", done, 1);
    chk(!wr_valid, "R10", "no write on empty run", wr_valid, 0);
    @(negedge clk);
    #1;
    chk(!done, "R10", "done falls", done, 0);
    chk(!wr_valid && !smp_ready, "R10", "idle after empty run", {wr_valid, smp_ready}, 0);

    // Directed: another run after the empty one starts cleanly at its base
    run_vec(8'h40, 4'd0, 16'h0010, 8'h21, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule